// File: doc/BRIEF.md
# Manchester Telegram Frame Decoder

This block decodes a low-frequency telegram that has already been demodulated and sampled. An external timing source delivers one strobe per half bit period, together with the line level at that instant. The block first hunts for a run of Manchester preamble bits followed by a SYNC pattern. It then checks a 0, 8 or 16 bit identifier against a stored reference. After that it shifts in data bytes, most significant bit first, until a half-bit pair appears that is not valid Manchester.

Each completed byte is moved into an output data register and raises a sticky data-ready flag. An interrupt line follows that flag while the interrupt enable is set. Coding errors, end of message, SYNC errors, data-rate (strobe gap) errors and identifier mismatches are reported as sticky status bits. An external sequencer reads these bits and a combined frame-error line, and decides whether to go back to listening. After any end or abort the decoder returns to hunting by itself.

Top module: `mtd_frame_decoder`

## Requirements
- R1: The decoder enters a frame only after at least PRE_MIN preamble zero bits (each sent as half bits high then low), followed directly by three high half bits. While hunting it never sets any flag.
- R2: `sync_sel` sets the SYNC length in half bits: 0 gives 12 (6 high, then 6 low), 1 gives 15 (8 high, then 7 low), and 2 or 3 give 18 (9 high, then 9 low). Any half bit that differs from this pattern sets `status_o[1]` and aborts the frame.
- R3: A bit period is valid when its two half-bit samples differ. Low then high decodes as 1 and high then low decodes as 0. Identifier and data bits are both taken most significant bit first.
- R4: `id_sel` sets the identifier length. 0 means no identifier. 1 means 8 bits compared with `id_ref[7:0]`. 2 or 3 means 16 bits compared with `id_ref[15:0]`. The first bit that differs sets `status_o[0]` and aborts the frame.
- R5: Each completed data byte is loaded into `data_o` and sets `drdy_o`. `irq_o` is high exactly while `drdy_o` and `irq_en` are both high.
- R6: An invalid pair on the first bit of a byte, including the bit right after the identifier, sets `status_o[4]` (end of message) and `status_o[3]` (coding error) and ends the frame. It leaves `drdy_o` unchanged.
- R7: An invalid pair in the middle of a byte sets only `status_o[3]` and discards the partial byte.
- R8: Inside a frame, MAX_GAP consecutive clocks without `half_stb` set `status_o[2]` and abort the frame.
- R9: `frame_err_o` is high when any of `status_o[2:0]` is set, or when `status_o[3]` is set without `status_o[4]`.
- R10: All flags are sticky. A one-cycle `clr` pulse clears `drdy_o` and `status_o` and leaves `data_o` unchanged.
- R11: While `rst` is high or `en` is low, the flags, `data_o` and the frame state are cleared. After every end or abort the decoder hunts again and accepts a following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Decoder enable; low holds everything cleared |
| half_stb | input | 1 | One-cycle strobe at each half-bit sample point |
| rx | input | 1 | Demodulated line level, valid with `half_stb` |
| sync_sel | input | 2 | SYNC length select |
| id_sel | input | 2 | Identifier length select |
| id_ref | input | ID_W | Stored identifier reference |
| irq_en | input | 1 | Data-ready interrupt enable |
| clr | input | 1 | One-cycle pulse that clears all flags |
| data_o | output | BYTE_W | Last completed data byte |
| drdy_o | output | 1 | Sticky data-ready flag |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 5 | Sticky flags: [0] ID mismatch, [1] SYNC error, [2] rate error, [3] coding error, [4] end of message |
| frame_err_o | output | 1 | Combined frame-error indication |

## Verification
The bench sends frames with every SYNC length and every identifier length. A SYNC of the wrong length shifts the identifier by a half bit, so the frame turns into a spurious coding error or mismatch. It ends frames both exactly on a byte boundary and partway through a byte, including telegrams with no data after the identifier. A decoder that confused these cases would report end of message for a broken byte, or would raise data-ready with no data. Strobe silence, a broken SYNC run, a single flipped identifier bit, clear pulses and disabling the decoder are each driven in turn. These stimuli expose flags that fail to stick, flags that clear the data register, or flags that survive a disable.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

   typedef enum logic [1:0] {
      ST_HUNT,
      ST_SYNC,
      ST_ID,
      ST_DATA
   } mtd_state_e;

   localparam int FL_IDERR = 0;
   localparam int FL_SYNC  = 1;
   localparam int FL_RATE  = 2;
   localparam int FL_CERR  = 3;
   localparam int FL_EOM   = 4;
   localparam int FL_DRDY  = 5;
   localparam int FL_N     = 6;
   localparam int SYNC_MAX = 18;

   function automatic int sync_halves(input logic [1:0] sel);
      case (sel)
         2'd0:    return 12;
         2'd1:    return 15;
         default: return 18;
      endcase
   endfunction

   function automatic int id_bits(input logic [1:0] sel, input int full_w);
      case (sel)
         2'd0:    return 0;
         2'd1:    return full_w / 2;
         default: return full_w;
      endcase
   endfunction

endpackage

// File: rtl/mtd_preamble_hunt.sv
module mtd_preamble_hunt #(
   parameter int PRE_MIN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic stb,
   input  logic rx,
   output logic hit
);
   localparam int HEAD = 3;
   localparam int W    = 2 * PRE_MIN + HEAD;

   logic [W-1:0] pat;
   logic [W-1:0] hist;
   logic [W-1:0] nxt;

   // newest sample at bit 0: three high halves, before them alternating L/H pairs
   for (genvar i = 0; i < W; i++) begin : g_pat
      if (i < HEAD) begin : g_head
         assign pat[i] = 1'b1;
      end else begin : g_pre
         assign pat[i] = ((i - HEAD) % 2) == 1;
      end
   end

   assign nxt = {hist[W-2:0], rx};
   assign hit = stb && (nxt == pat);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         hist <= '0;
      end else if (stb) begin
         hist <= nxt;
      end
   end
endmodule

// File: rtl/mtd_gap_timer.sv
module mtd_gap_timer #(
   parameter int MAX_GAP = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic stb,
   output logic expire
);
   localparam int GW = $clog2(MAX_GAP);

   logic [GW-1:0] cnt;

   assign expire = run && !stb && (cnt == GW'(MAX_GAP - 1));

   always_ff @(posedge clk) begin
      if (rst || !run || stb || expire) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mtd_sticky_flags.sv
module mtd_sticky_flags #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wipe,
   input  logic         clr,
   input  logic [N-1:0] set,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst || wipe) begin
            q[i] <= 1'b0;
         end else if (set[i]) begin
            q[i] <= 1'b1;
         end else if (clr) begin
            q[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mtd_frame_decoder.sv
module mtd_frame_decoder #(
   parameter int PRE_MIN = 4,
   parameter int BYTE_W  = 8,
   parameter int ID_W    = 16,
   parameter int MAX_GAP = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              half_stb,
   input  logic              rx,
   input  logic [1:0]        sync_sel,
   input  logic [1:0]        id_sel,
   input  logic [ID_W-1:0]   id_ref,
   input  logic              irq_en,
   input  logic              clr,
   output logic [BYTE_W-1:0] data_o,
   output logic              drdy_o,
   output logic              irq_o,
   output logic [4:0]        status_o,
   output logic              frame_err_o
);
   import mtd_pkg::*;

   localparam int CNT_MAX = (ID_W > SYNC_MAX) ? ((ID_W > BYTE_W) ? ID_W : BYTE_W)
                                              : ((SYNC_MAX > BYTE_W) ? SYNC_MAX : BYTE_W);
   localparam int CW = $clog2(CNT_MAX + 1);

   if (PRE_MIN < 1) begin : g_bad_pre
      $error("PRE_MIN must be at least 1");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end
   if ((ID_W < 2) || (ID_W % 2) != 0) begin : g_bad_id
      $error("ID_W must be even and at least 2");
   end
   if (MAX_GAP < 4) begin : g_bad_gap
      $error("MAX_GAP must be at least 4");
   end

   mtd_state_e        st, st_n;
   logic [CW-1:0]     cnt, cnt_n;
   logic              ph, ph_n;
   logic              h0, h0_n;
   logic [BYTE_W-2:0] sh, sh_n;
   logic [BYTE_W-1:0] byte_nxt;
   logic              load;
   logic [FL_N-1:0]   setv;
   logic [FL_N-1:0]   flg;
   logic              hit, gap_exp;
   logic [CW-1:0]     slen, shi, idl, id_idx;
   logic              id_exp, bitv, pair_ok;

   assign slen   = CW'(sync_halves(sync_sel));
   assign shi    = CW'((sync_halves(sync_sel) + 1) / 2);
   assign idl    = CW'(id_bits(id_sel, ID_W));
   assign id_idx = idl - cnt - 1'b1;

   always_comb begin
      id_exp = 1'b0;
      for (int k = 0; k < ID_W; k++) begin
         if (id_idx == CW'(k)) id_exp = id_ref[k];
      end
   end

   assign bitv     = rx;
   assign pair_ok  = (h0 != rx);
   assign byte_nxt = {sh, bitv};

   mtd_preamble_hunt #(.PRE_MIN(PRE_MIN)) u_hunt (
      .clk   (clk),
      .rst   (rst),
      .clear (!en || (st != ST_HUNT)),
      .stb   (half_stb),
      .rx    (rx),
      .hit   (hit)
   );

   mtd_gap_timer #(.MAX_GAP(MAX_GAP)) u_gap (
      .clk    (clk),
      .rst    (rst),
      .run    (en && (st != ST_HUNT)),
      .stb    (half_stb),
      .expire (gap_exp)
   );

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      ph_n  = ph;
      h0_n  = h0;
      sh_n  = sh;
      load  = 1'b0;
      setv  = '0;
      if (gap_exp) begin
         setv[FL_RATE] = 1'b1;
         st_n          = ST_HUNT;
      end else if (half_stb) begin
         case (st)
            ST_HUNT: begin
               if (hit) begin
                  st_n  = ST_SYNC;
                  cnt_n = CW'(3);
               end
            end
            ST_SYNC: begin
               if (rx != (cnt < shi)) begin
                  setv[FL_SYNC] = 1'b1;
                  st_n          = ST_HUNT;
               end else if (cnt == slen - 1'b1) begin
                  cnt_n = '0;
                  ph_n  = 1'b0;
                  st_n  = (idl == '0) ? ST_DATA : ST_ID;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            default: begin
               if (!ph) begin
                  h0_n = rx;
                  ph_n = 1'b1;
               end else begin
                  ph_n = 1'b0;
                  if (!pair_ok) begin
                     setv[FL_CERR] = 1'b1;
                     setv[FL_EOM]  = (st == ST_DATA) && (cnt == '0);
                     st_n          = ST_HUNT;
                  end else if (st == ST_ID) begin
                     if (bitv != id_exp) begin
                        setv[FL_IDERR] = 1'b1;
                        st_n           = ST_HUNT;
                     end else if (cnt == idl - 1'b1) begin
                        cnt_n = '0;
                        st_n  = ST_DATA;
                     end else begin
                        cnt_n = cnt + 1'b1;
                     end
                  end else begin
                     sh_n = byte_nxt[BYTE_W-2:0];
                     if (cnt == CW'(BYTE_W - 1)) begin
                        load          = 1'b1;
                        setv[FL_DRDY] = 1'b1;
                        cnt_n         = '0;
                     end else begin
                        cnt_n = cnt + 1'b1;
                     end
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         st  <= ST_HUNT;
         cnt <= '0;
         ph  <= 1'b0;
         h0  <= 1'b0;
         sh  <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
         ph  <= ph_n;
         h0  <= h0_n;
         sh  <= sh_n;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         data_o <= '0;
      end else if (load) begin
         data_o <= byte_nxt;
      end
   end

   mtd_sticky_flags #(.N(FL_N)) u_flags (
      .clk  (clk),
      .rst  (rst),
      .wipe (!en),
      .clr  (clr),
      .set  (setv),
      .q    (flg)
   );

   assign status_o    = flg[FL_EOM:FL_IDERR];
   assign drdy_o      = flg[FL_DRDY];
   assign irq_o       = drdy_o && irq_en;
   assign frame_err_o = flg[FL_IDERR] || flg[FL_SYNC] || flg[FL_RATE]
                        || (flg[FL_CERR] && !flg[FL_EOM]);
endmodule

// File: rtl/mtd_frame_checker.sv
module mtd_frame_checker #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic              half_stb,
   input logic              clr,
   input logic [BYTE_W-1:0] data_o,
   input logic              drdy_o,
   input logic [4:0]        status_o
);
   AST_EOM_WITH_CERR: assert property (@(posedge clk) disable iff (rst)
      status_o[4] |-> status_o[3]); // R6

   AST_DRDY_STICKY: assert property (@(posedge clk) disable iff (rst)
      (drdy_o && en && !clr) |=> drdy_o); // R10

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!drdy_o && (status_o == 5'd0) && (data_o == '0))); // R11

   AST_DATA_ONLY_WITH_DRDY: assert property (@(posedge clk) disable iff (rst)
      (en && $past(en) && !$stable(data_o)) |-> drdy_o); // R5

   AST_RATE_AFTER_SILENCE: assert property (@(posedge clk) disable iff (rst)
      $rose(status_o[2]) |-> !$past(half_stb)); // R8

   AST_SYNC_ERR_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      $rose(status_o[1]) |-> $past(half_stb)); // R2

   AST_ID_ERR_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      $rose(status_o[0]) |-> $past(half_stb)); // R4
endmodule

bind mtd_frame_decoder mtd_frame_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .half_stb (half_stb),
   .clr      (clr),
   .data_o   (data_o),
   .drdy_o   (drdy_o),
   .status_o (status_o)
);

// File: tb/mtd_frame_decoder_test.sv
`timescale 1ns/1ps
module mtd_frame_decoder_test;
   localparam int PRE_MIN = 4;
   localparam int MAX_GAP = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b1;
   logic        half_stb = 1'b0;
   logic        rx = 1'b0;
   logic [1:0]  sync_sel = 2'd0;
   logic [1:0]  id_sel = 2'd0;
   logic [15:0] id_ref = 16'hA53C;
   logic        irq_en = 1'b1;
   logic        clr = 1'b0;
   logic [7:0]  data_o;
   logic        drdy_o, irq_o, frame_err_o;
   logic [4:0]  status_o;

   int   n_run = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   logic [7:0] exp_data = 8'h00;
   logic [7:0] fb [4];

   always #2.5 clk = ~clk;

   mtd_frame_decoder #(.PRE_MIN(PRE_MIN), .BYTE_W(8), .ID_W(16), .MAX_GAP(MAX_GAP)) uut (
      .clk(clk), .rst(rst), .en(en), .half_stb(half_stb), .rx(rx),
      .sync_sel(sync_sel), .id_sel(id_sel), .id_ref(id_ref), .irq_en(irq_en),
      .clr(clr), .data_o(data_o), .drdy_o(drdy_o), .irq_o(irq_o),
      .status_o(status_o), .frame_err_o(frame_err_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic half(input logic b);
      @(negedge clk);
      rx = b;
      half_stb = 1'b1;
      @(negedge clk);
      half_stb = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic mbit(input logic b);
      half(~b);
      half(b);
   endtask

   task automatic viol();
      half(1'b1);
      half(1'b1);
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   function automatic int sync_len(input logic [1:0] s);
      return (s == 2'd0) ? 12 : (s == 2'd1) ? 15 : 18;
   endfunction

   function automatic int id_len(input logic [1:0] s);
      return (s == 2'd0) ? 0 : (s == 2'd1) ? 8 : 16;
   endfunction

   task automatic head(input int pre_n, input logic [1:0] s);
      repeat (3) half(1'b0);
      repeat (pre_n) mbit(1'b0);
      for (int i = 0; i < sync_len(s); i++) half(i < (sync_len(s) + 1) / 2);
   endtask

   task automatic send_id(input logic [1:0] s, input logic [15:0] v);
      for (int i = id_len(s) - 1; i >= 0; i--) mbit(v[i]);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) mbit(b[i]);
   endtask

   // expected outcome of one frame from the requirements
   task automatic check_frame(input string tag, input bit id_ok, input int nb, input int part);
      logic [4:0] es;
      logic       ed;
      if (!id_ok) begin
         es = 5'b00001;
         ed = 1'b0;
      end else begin
         es = (part == 0) ? 5'b11000 : 5'b01000;
         ed = (nb > 0);
         if (nb > 0) exp_data = fb[nb-1];
      end
      repeat (4) @(negedge clk);
      chk({tag, " R4/R6/R7 status"}, 32'(status_o), 32'(es));
      chk({tag, " R5 drdy"}, 32'(drdy_o), 32'(ed));
      chk({tag, " R5 data"}, 32'(data_o), 32'(exp_data));
      chk({tag, " R5 irq"}, 32'(irq_o), 32'(ed && irq_en));
      chk({tag, " R9 frame_err"}, 32'(frame_err_o), 32'(!id_ok || part != 0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] idv;
      logic [1:0]  ss, is;
      int          nb, part, pre_n;
      bit          id_ok;
      void'($urandom(32'h5EED1234));
      repeat (5) @(negedge clk);
      chk("R11 reset status", 32'(status_o), 32'd0);
      chk("R11 reset drdy", 32'(drdy_o), 32'd0);
      chk("R11 reset data", 32'(data_o), 32'd0);
      rst = 1'b0;

      // R1: too short a preamble is ignored, then no flags
      repeat (3) half(1'b0);
      repeat (PRE_MIN - 1) mbit(1'b0);
      for (int i = 0; i < 12; i++) half(i < 6);
      mbit(1'b0); viol();
      repeat (4) @(negedge clk);
      chk("R1 short preamble no flags", 32'({status_o, drdy_o}), 32'd0);

      // R6: telegram ends right after the ID
      sync_sel = 2'd0; id_sel = 2'd2;
      head(PRE_MIN, 2'd0); send_id(2'd2, id_ref); viol(); repeat (3) half(1'b0);
      check_frame("R6 end after ID", 1'b1, 0, 0);
      pulse_clr();

      // R5: data-ready per byte, clr keeps data (R10)
      sync_sel = 2'd1; id_sel = 2'd1;
      head(PRE_MIN + 1, 2'd1); send_id(2'd1, id_ref); send_byte(8'h96);
      repeat (2) @(negedge clk);
      chk("R5 first byte drdy", 32'(drdy_o), 32'd1);
      chk("R3 first byte msb first", 32'(data_o), 32'h96);
      pulse_clr();
      chk("R10 clr clears drdy", 32'(drdy_o), 32'd0);
      chk("R10 clr keeps data", 32'(data_o), 32'h96);
      send_byte(8'h3C); viol(); repeat (3) half(1'b0);
      fb[0] = 8'h96; fb[1] = 8'h3C;
      check_frame("R5 two bytes", 1'b1, 2, 0);
      pulse_clr();
      chk("R10 clr clears status", 32'(status_o), 32'd0);

      // R2: broken SYNC run
      sync_sel = 2'd0;
      repeat (3) half(1'b0); repeat (PRE_MIN) mbit(1'b0);
      half(1'b1); half(1'b1); half(1'b1); half(1'b1); half(1'b0);
      repeat (6) half(1'b0);
      repeat (4) @(negedge clk);
      chk("R2 sync error status", 32'(status_o), 32'b00010);
      chk("R9 sync error frame_err", 32'(frame_err_o), 32'd1);
      pulse_clr();

      // R8: strobes stop inside the ID
      id_sel = 2'd2;
      head(PRE_MIN, 2'd0); mbit(id_ref[15]); mbit(id_ref[14]);
      repeat (MAX_GAP + 20) @(negedge clk);
      chk("R8 rate error status", 32'(status_o), 32'b00100);
      chk("R9 rate error frame_err", 32'(frame_err_o), 32'd1);
      pulse_clr();

      // R11: disable clears everything, decoder hunts again afterwards
      id_sel = 2'd0;
      head(PRE_MIN, 2'd0); send_byte(8'h5A); viol(); repeat (3) half(1'b0);
      fb[0] = 8'h5A;
      check_frame("R11 frame before disable", 1'b1, 1, 0);
      @(negedge clk); en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 disable status", 32'(status_o), 32'd0);
      chk("R11 disable drdy", 32'(drdy_o), 32'd0);
      chk("R11 disable data", 32'(data_o), 32'd0);
      en = 1'b1; exp_data = 8'h00;

      // random frames
      for (int f = 0; f < 40; f++) begin
         ss = 2'($urandom_range(0, 3));
         is = 2'($urandom_range(0, 3));
         nb = $urandom_range(0, 3);
         part = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 7) : 0;
         pre_n = PRE_MIN + $urandom_range(0, 3);
         irq_en = 1'($urandom_range(0, 1));
         idv = id_ref;
         id_ok = 1'b1;
         if (is != 2'd0 && $urandom_range(0, 4) == 0) begin
            idv[$urandom_range(0, id_len(is) - 1)] ^= 1'b1;
            id_ok = 1'b0;
         end
         for (int k = 0; k < 4; k++) fb[k] = 8'($urandom);
         sync_sel = ss; id_sel = is;
         head(pre_n, ss);
         send_id(is, idv);
         for (int k = 0; k < nb; k++) send_byte(fb[k]);
         for (int k = 0; k < part; k++) mbit(1'($urandom));
         viol();
         repeat (3) half(1'b0);
         check_frame($sformatf("R2/R3 rnd%0d", f), id_ok, nb, part);
         pulse_clr();
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule